// File: doc/BRIEF.md
# Receive Frame Buffer with Overflow Recovery

This block takes frames from a receive MAC as a stream of words marked with start and end flags, and holds them for a reader that drains them through a valid/ready word port. Frame data goes into a data memory; a per-frame status word (length, error, undersized and truncation flags, plus an optional second status word) goes into a separate status queue, which the reader drains through its own valid/ready port. The MAC side cannot be stalled, so when the data memory runs out of room before a frame's end arrives, the block has to recover on its own.

It recovers in one of two ways, depending on how much of the frame the reader may already have seen. If no word of the frame has been made readable yet, the write pointer goes back to where the frame began, and the frame leaves no trace apart from a missed-frame counter step. If the frame was already readable, which happens in cut-through mode once a threshold of words is buffered, the rest of the frame is thrown away. A zero word carrying the end flag closes the frame, and a status marked partial with a zero length follows. In store-and-forward mode a frame only becomes readable once it is complete, so an oversize frame is always dropped whole. Frames with errors and undersized frames can be filtered, but only while they are not yet readable.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset, rd_valid and st_valid are 0 and ovf_count is 0.
- R2: With cfg_saf=1, no word of a frame is readable before its end word is stored. A frame that fits is read back in order with rd_eof set only on its last word. Its status word holds bit 31 = partial, bit 30 = error (in_err on the end word), bit 29 = undersized (fewer than MIN_WORDS words), bits 15:0 = length in words, and all other bits 0.
- R3: The data memory holds at most 2^AW-1 frame words. A frame that overflows before any of its words is readable leaves nothing in either queue, earlier frames stay intact, and ovf_count rises by 1. In store-and-forward mode this covers every frame longer than 2^AW-1 words.
- R4: A frame that overflows after it became readable keeps the words already stored. A word with data 0 and rd_eof=1 is appended, and the status word is 32'h8000_0000 (partial set, length 0). The remaining input words of the frame are discarded and ovf_count rises by 1.
- R5: With cfg_saf=0, a frame becomes readable on the cycle after the word that brings its stored count to cfg_thresh.
- R6: With cfg_drop_err=1, a frame whose end word has in_err=1 and which is not yet readable is discarded without a status word and without changing ovf_count.
- R7: With cfg_drop_short=1, an undersized frame that is not yet readable at its end is discarded the same way.
- R8: A frame that is already readable when its end word arrives is always delivered, with its error and undersized flags in its status, whatever the filter settings.
- R9: If cfg_ext=1 when a status entry is stored, the status is delivered as two beats: first the main word with st_last=0, then in_xstat as sampled on the end word with st_last=1. For a truncated frame the second word is 0.
- R10: ovf_count holds at its maximum value instead of wrapping.
- R11: The status queue holds 2^AW/MIN_WORDS entries. A frame whose start word arrives while it is full is dropped and counted in ovf_count.
- R12: While rd_valid (st_valid) is 1 and rd_ready (st_ready) is 0, the read word (status beat) does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_saf | input | 1 | 1 = store-and-forward, 0 = cut-through (sampled at frame start) |
| cfg_thresh | input | AW+1 | Cut-through release threshold in words |
| cfg_drop_err | input | 1 | Discard unreleased frames ending with an error |
| cfg_drop_short | input | 1 | Discard unreleased undersized frames |
| cfg_ext | input | 1 | Deliver a second status word per frame |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_err | input | 1 | Frame error, valid with in_eof |
| in_data | input | DW | Frame data word |
| in_xstat | input | 32 | Extended status, valid with in_eof |
| rd_valid | output | 1 | Read word available |
| rd_data | output | DW | Read word |
| rd_eof | output | 1 | Read word ends a frame |
| rd_ready | input | 1 | Reader takes the word |
| st_valid | output | 1 | Status beat available |
| st_data | output | 32 | Status beat |
| st_last | output | 1 | Final beat of this status entry |
| st_ready | input | 1 | Reader takes the status beat |
| ovf_count | output | CNT_W | Saturating missed/overflow frame counter |

## Verification
The assertions assume the input is well formed: a frame opens with in_sof, closes with in_eof, and no start word appears inside an open frame. They also assume rd_ready and st_ready are only meaningful while the matching valid is high. The stimulus always sends complete frames, one word per cycle, with starts and ends only at frame boundaries. Overflow is reached by holding the reader idle rather than by sending broken framing, and the ready signals are raised only after the bench has seen valid.

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer #(
  parameter int DW        = 32,
  parameter int AW        = 9,
  parameter int MIN_WORDS = 16,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_saf,
  input  logic [AW:0]      cfg_thresh,
  input  logic             cfg_drop_err,
  input  logic             cfg_drop_short,
  input  logic             cfg_ext,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_err,
  input  logic [DW-1:0]    in_data,
  input  logic [31:0]      in_xstat,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             rd_eof,
  input  logic             rd_ready,
  output logic             st_valid,
  output logic [31:0]      st_data,
  output logic             st_last,
  input  logic             st_ready,
  output logic [CNT_W-1:0] ovf_count
);
  localparam int DEPTH  = 1 << AW;
  localparam int LW     = AW + 1;
  localparam int SDEPTH = DEPTH / MIN_WORDS;
  localparam int SAW    = $clog2(SDEPTH);
  localparam logic [LW-1:0]  ROOM   = LW'(DEPTH - 1);
  localparam logic [LW-1:0]  MINLEN = LW'(MIN_WORDS);
  localparam logic [SAW:0]   SFULL  = (SAW + 1)'(SDEPTH);

  logic [DW:0]    dmem [DEPTH];
  logic [64:0]    smem [SDEPTH];
  logic [LW-1:0]  wr_ptr, rd_ptr, vis_ptr, sof_ptr, wcnt;
  logic [SAW:0]   s_wp, s_rp;
  logic           in_frame, dropping, rel, saf_q, beat;

  logic s_full;
  assign s_full = (s_wp - s_rp) == SFULL;

  logic          starting, active, c_drop, c_rel, c_saf;
  logic [LW-1:0] c_cnt, c_base, occ, n;
  assign starting = in_valid & in_sof;
  assign active   = starting | (in_valid & in_frame);
  assign c_drop   = starting ? s_full : dropping;
  assign c_rel    = starting ? 1'b0 : rel;
  assign c_saf    = starting ? cfg_saf : saf_q;
  assign c_cnt    = starting ? '0 : wcnt;
  assign c_base   = starting ? wr_ptr : sof_ptr;
  assign occ      = wr_ptr - rd_ptr;
  assign n        = c_cnt + LW'(1);

  logic space, short_f, filt, take, ovf, wr_word, wr_dummy;
  logic commit, reject, release_now, show, s_push, miss;
  assign space       = occ < ROOM;
  assign short_f     = n < MINLEN;
  assign filt        = (cfg_drop_err & in_err) | (cfg_drop_short & short_f);
  assign take        = active & ~c_drop;
  assign ovf         = take & ~space;
  assign wr_word     = take & space;
  assign wr_dummy    = ovf & c_rel;
  assign reject      = wr_word & in_eof & filt & ~c_rel;
  assign commit      = wr_word & in_eof & ~reject;
  assign release_now = wr_word & ~in_eof & ~c_rel & ~c_saf & (n >= cfg_thresh);
  assign show        = wr_dummy | commit | release_now | (wr_word & c_rel);
  assign s_push      = commit | wr_dummy;
  assign miss        = (starting & s_full) | ovf;

  logic [31:0] main_w, ext_w;
  assign main_w = wr_dummy ? 32'h8000_0000
                           : {1'b0, in_err, short_f, 13'b0, 16'(n)};
  assign ext_w  = wr_dummy ? 32'h0 : in_xstat;

  always_ff @(posedge clk) begin
    if (wr_word | wr_dummy)
      dmem[wr_ptr[AW-1:0]] <= wr_dummy ? {1'b1, {DW{1'b0}}} : {in_eof, in_data};
    if (s_push)
      smem[s_wp[SAW-1:0]] <= {cfg_ext, main_w, ext_w};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      vis_ptr   <= '0;
      sof_ptr   <= '0;
      wcnt      <= '0;
      s_wp      <= '0;
      s_rp      <= '0;
      in_frame  <= 1'b0;
      dropping  <= 1'b0;
      rel       <= 1'b0;
      saf_q     <= 1'b1;
      beat      <= 1'b0;
      ovf_count <= '0;
    end else begin
      if ((ovf & ~c_rel) | reject)  wr_ptr <= c_base;
      else if (wr_word | wr_dummy)  wr_ptr <= wr_ptr + LW'(1);
      if (show) vis_ptr <= wr_ptr + LW'(1);
      if (starting) begin
        sof_ptr <= wr_ptr;
        saf_q   <= cfg_saf;
      end
      if (active) begin
        in_frame <= ~in_eof;
        dropping <= ~in_eof & (c_drop | ovf);
        rel      <= ~in_eof & (c_rel | release_now);
        wcnt     <= n;
      end
      if (rd_valid & rd_ready) rd_ptr <= rd_ptr + LW'(1);
      if (s_push) s_wp <= s_wp + (SAW + 1)'(1);
      if (st_valid & st_ready) begin
        beat <= ~st_last;
        if (st_last) s_rp <= s_rp + (SAW + 1)'(1);
      end
      if (miss && ovf_count != {CNT_W{1'b1}}) ovf_count <= ovf_count + CNT_W'(1);
    end
  end

  logic [64:0] s_head;
  assign s_head            = smem[s_rp[SAW-1:0]];
  assign rd_valid          = rd_ptr != vis_ptr;
  assign {rd_eof, rd_data} = dmem[rd_ptr[AW-1:0]];
  assign st_valid          = s_wp != s_rp;
  assign st_data           = beat ? s_head[31:0] : s_head[63:32];
  assign st_last           = ~s_head[64] | beat;
endmodule

// File: rtl/rx_frame_buffer_chk.sv
module rx_frame_buffer_chk #(
  parameter int DW    = 32,
  parameter int AW    = 9,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [DW-1:0]    rd_data,
  input logic             rd_eof,
  input logic             st_valid,
  input logic             st_ready,
  input logic [31:0]      st_data,
  input logic             st_last,
  input logic             beat,
  input logic [AW:0]      wr_ptr,
  input logic [AW:0]      rd_ptr,
  input logic [CNT_W-1:0] ovf_count
);
  localparam logic [AW:0] DEPTH = (AW + 1)'(1 << AW);

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_eof));

  p_st_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last));

  p_partial_len_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !beat && st_data[31] |-> st_data[30:0] == 31'h0);

  p_ext_second_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && !st_last |=> st_valid && st_last);

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr - rd_ptr) <= DEPTH);

  p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, ovf_count} >= {1'b0, $past(ovf_count)}) &&
             ({1'b0, ovf_count} <= {1'b0, $past(ovf_count)} + (CNT_W + 1)'(1)));

  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_count == {CNT_W{1'b1}} |=> ovf_count == {CNT_W{1'b1}});
endmodule

bind rx_frame_buffer rx_frame_buffer_chk #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_eof(rd_eof),
  .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_last(st_last),
  .beat(beat), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ovf_count(ovf_count)
);

// File: tb/rx_frame_buffer_tb.sv
module rx_frame_buffer_tb;
  localparam int DW = 32, AW = 4, MINW = 4, CW = 3;
  localparam int CAP = (1 << AW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_saf = 1'b1, cfg_drop_err = 1'b0, cfg_drop_short = 1'b0, cfg_ext = 1'b0;
  logic [AW:0] cfg_thresh = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [31:0] in_xstat = '0;
  logic rd_valid, rd_eof, rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic st_valid, st_last, st_ready = 1'b0;
  logic [31:0] st_data;
  logic [CW-1:0] ovf_count;

  int checks = 0, errors = 0, exp_cnt = 0;

  always #10 clk = ~clk;

  rx_frame_buffer #(.DW(DW), .AW(AW), .MIN_WORDS(MINW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_saf(cfg_saf), .cfg_thresh(cfg_thresh),
    .cfg_drop_err(cfg_drop_err), .cfg_drop_short(cfg_drop_short), .cfg_ext(cfg_ext),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .in_data(in_data), .in_xstat(in_xstat),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_eof(rd_eof), .rd_ready(rd_ready),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready),
    .ovf_count(ovf_count));

  // {len[43:36], err[35], drop_err[34], drop_short[33], delivered[32], status[31:0]}
  localparam logic [43:0] VEC [10] = '{
    {8'd5,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0005},
    {8'd1,  1'b0, 1'b0, 1'b0, 1'b1, 32'h2000_0001},
    {8'd3,  1'b1, 1'b0, 1'b0, 1'b1, 32'h6000_0003},
    {8'd6,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0},
    {8'd2,  1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    {8'd4,  1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0004},
    {8'd15, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_000F},
    {8'd16, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
    {8'd7,  1'b1, 1'b0, 1'b1, 1'b1, 32'h4000_0007},
    {8'd2,  1'b0, 1'b1, 1'b0, 1'b1, 32'h2000_0002}
  };

  function automatic logic [31:0] word_of(input int tag, input int i);
    return {16'(tag), 16'(i + 1)};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bump();
    if (exp_cnt < CMAX) exp_cnt++;
  endtask

  task automatic drive_word(input int tag, input int i, input bit sof, input bit eof,
                            input bit err, input logic [31:0] xs);
    in_valid = 1'b1; in_sof = sof; in_eof = eof; in_err = eof & err;
    in_data = word_of(tag, i); in_xstat = xs;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
  endtask

  task automatic send(input int tag, input int len, input bit err,
                      input logic [31:0] xs, input bit hold_chk);
    for (int i = 0; i < len; i++) begin
      if (hold_chk && i > 0) chk({31'b0, rd_valid}, 32'h0, "R2 early read");
      drive_word(tag, i, i == 0, i == len - 1, err, xs);
    end
  endtask

  task automatic read_word(input logic [31:0] d, input bit eof, input string req);
    chk({31'b0, rd_valid}, 32'h1, req);
    chk(rd_data, d, req);
    chk({31'b0, rd_eof}, {31'b0, eof}, req);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic expect_frame(input int tag, input int len, input string req);
    for (int i = 0; i < len; i++) read_word(word_of(tag, i), i == len - 1, req);
  endtask

  task automatic read_status(input logic [31:0] s, input bit last, input string req);
    chk({31'b0, st_valid}, 32'h1, req);
    chk(st_data, s, req);
    chk({31'b0, st_last}, {31'b0, last}, req);
    st_ready = 1'b1;
    @(negedge clk);
    st_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    chk({31'b0, rd_valid}, 32'h0, req);
    chk({31'b0, st_valid}, 32'h0, req);
  endtask

  task automatic chk_cnt(input string req);
    chk(32'(ovf_count), 32'(exp_cnt), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_empty("R1");
    chk_cnt("R1");

    // table of store-and-forward frames
    for (int k = 0; k < 10; k++) begin
      logic [43:0] v;
      int len;
      string req;
      v = VEC[k];
      len = int'(v[43:36]);
      req = (len > CAP) ? "R3" : (v[35] && v[34]) ? "R6" :
            (v[33] && len < MINW) ? "R7" : "R2";
      cfg_saf = 1'b1; cfg_drop_err = v[34]; cfg_drop_short = v[33];
      send(k + 1, len, v[35], 32'h0, 1'b1);
      if (len > CAP) bump();
      @(negedge clk);
      if (v[32]) begin
        expect_frame(k + 1, len, req);
        read_status(v[31:0], 1'b1, req);
      end
      expect_empty(req);
      chk_cnt(req);
    end
    cfg_drop_err = 1'b0; cfg_drop_short = 1'b0;

    // R5 cut-through release at threshold
    cfg_saf = 1'b0; cfg_thresh = 5'd3;
    drive_word(20, 0, 1, 0, 0, 0);
    chk({31'b0, rd_valid}, 32'h0, "R5 below threshold");
    drive_word(20, 1, 0, 0, 0, 0);
    chk({31'b0, rd_valid}, 32'h0, "R5 below threshold");
    drive_word(20, 2, 0, 0, 0, 0);
    chk({31'b0, rd_valid}, 32'h1, "R5 released");
    drive_word(20, 3, 0, 1, 0, 0);
    expect_frame(20, 4, "R5");
    read_status(32'h0000_0004, 1'b1, "R5");
    expect_empty("R5");

    // R8 released undersized frame survives the filter
    cfg_thresh = 5'd2; cfg_drop_short = 1'b1;
    send(21, 3, 1'b0, 32'h0, 1'b0);
    expect_frame(21, 3, "R8");
    read_status(32'h2000_0003, 1'b1, "R8");
    expect_empty("R8");
    // R7 same frame, not yet released at its end
    cfg_thresh = 5'd8;
    send(22, 3, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    expect_empty("R7 cut-through drop");
    chk_cnt("R7");
    cfg_drop_short = 1'b0;

    // R9 extended status and R12 hold
    cfg_saf = 1'b1; cfg_ext = 1'b1;
    send(23, 4, 1'b0, 32'hA5A5_1234, 1'b1);
    @(negedge clk);
    begin
      logic [31:0] d0, s0;
      d0 = rd_data; s0 = st_data;
      repeat (2) @(negedge clk);
      chk(rd_data, d0, "R12 data hold");
      chk(st_data, s0, "R12 status hold");
      chk({31'b0, rd_valid}, 32'h1, "R12 valid hold");
    end
    expect_frame(23, 4, "R9");
    read_status(32'h0000_0004, 1'b0, "R9");
    read_status(32'hA5A5_1234, 1'b1, "R9");
    expect_empty("R9");

    // R4 truncation of a released frame (ext still on)
    cfg_saf = 1'b0; cfg_thresh = 5'd2;
    send(24, 20, 1'b0, 32'h1111_2222, 1'b0);
    bump();
    @(negedge clk);
    for (int i = 0; i < CAP; i++) read_word(word_of(24, i), 1'b0, "R4 kept word");
    read_word(32'h0, 1'b1, "R4 dummy end");
    read_status(32'h8000_0000, 1'b0, "R4 partial status");
    read_status(32'h0, 1'b1, "R9 truncated ext");
    expect_empty("R4");
    chk_cnt("R4");
    cfg_ext = 1'b0;

    // R3 rollback keeps the earlier frame
    cfg_saf = 1'b1;
    send(25, 5, 1'b0, 32'h0, 1'b0);
    send(26, 12, 1'b0, 32'h0, 1'b0);
    bump();
    @(negedge clk);
    expect_frame(25, 5, "R3");
    read_status(32'h0000_0005, 1'b1, "R3");
    expect_empty("R3");
    chk_cnt("R3");

    // R11 status queue full
    for (int t = 0; t < 4; t++) send(30 + t, 1, 1'b0, 32'h0, 1'b0);
    send(34, 2, 1'b0, 32'h0, 1'b0);
    bump();
    @(negedge clk);
    chk_cnt("R11");
    for (int t = 0; t < 4; t++) begin
      expect_frame(30 + t, 1, "R11");
      read_status(32'h2000_0001, 1'b1, "R11");
    end
    expect_empty("R11");
    send(35, 4, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    expect_frame(35, 4, "R11 after drain");
    read_status(32'h0000_0004, 1'b1, "R11 after drain");

    // R10 saturation
    for (int t = 0; t < 5; t++) begin
      send(40 + t, CAP + 1, 1'b0, 32'h0, 1'b0);
      bump();
      @(negedge clk);
      chk_cnt("R10");
      expect_empty("R10");
    end
    chk(32'(ovf_count), 32'(CMAX), "R10 saturated");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule